// File: doc/BRIEF.md
# Processor-to-ISA I/O Window Bridge

This block sits between a processor's memory-mapped request port and a 16-bit ISA-style I/O port bus. Any processor access that lands inside an 8 MB window based at physical address 0x80000000 is claimed. It is turned into one I/O cycle whose port number comes from the window offset. The bridge has two ways of forming that port number. In contiguous mode the offset is simply cut to 16 bits. In sparse mode the bits of the offset from bit 12 upward are moved down beside the lowest five bits, so that every 4 KB page of the window reaches 32 consecutive ports.

Data moves in bytes, halfwords or words. When the processor side is configured as big-endian, halfword and word data are byte-reversed on the way out and on the way back. Byte data always passes straight through. The map-mode and endian inputs are captured when an access is accepted, so changing them cannot disturb an access already in progress.

One access is outstanding at a time. The I/O request is held until the device acknowledges it. The processor acknowledge, with any read data, follows one cycle later as a single-cycle pulse.

Top module: `isa_io_window_bridge`

## Requirements
- R1: After synchronous reset, io_req and cpu_ack are low, and cpu_rdata and io_port are zero.
- R2: An idle bridge that sees cpu_req with an address in [0x80000000, 0x80800000) and a size code of 0 (byte), 1 (halfword) or 2 (word) raises io_req on the next clock edge and drives io_size and io_we from the request.
- R3: A request whose address is outside the window, or whose size code is 3, is not claimed: io_req and cpu_ack stay low for as long as the request is held.
- R4: With map_sparse = 0, io_port equals bits [15:0] of the offset (address minus 0x80000000).
- R5: With map_sparse = 1, io_port equals {offset[22:12], offset[4:0]}: offset bits 22..12 are placed in port bits 15..5, and offset bits 4..0 in port bits 4..0.
- R6: A byte access (size 0) never swaps. io_wdata is {24'b0, cpu_wdata[7:0]}, and cpu_rdata is {24'b0, io_rdata[7:0]}.
- R7: A halfword access (size 1) carries only the low 16 bits, with the upper bits zero. With big_endian = 1 the two bytes are exchanged in both directions. With big_endian = 0 they pass unchanged.
- R8: A word access (size 2) with big_endian = 1 reverses the four bytes in both directions (byte 0 becomes byte 3, and so on). With big_endian = 0 the word passes unchanged.
- R9: While io_req is high and io_ack is low, io_req, io_port and io_wdata hold steady. On the edge where io_ack is seen, io_req drops and cpu_ack rises for exactly one cycle, carrying the read data.
- R10: map_sparse and big_endian are sampled when the access is accepted. Changing them afterwards alters neither the port nor the read-data swap of that access.
- R11: A request still held during the cpu_ack cycle is not accepted at the following edge. The bridge spends one cycle idle before it can start the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sparse | input | 1 | 0 selects contiguous port mapping, 1 selects sparse mapping |
| big_endian | input | 1 | 1 enables byte swapping for halfword and word accesses |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| cpu_addr | input | 32 | Processor physical address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data returned with cpu_ack |
| io_req | output | 1 | I/O cycle request, held until io_ack |
| io_we | output | 1 | I/O cycle direction |
| io_size | output | 2 | I/O cycle size code |
| io_port | output | 16 | I/O port address |
| io_wdata | output | 32 | I/O write data, lane-adjusted |
| io_ack | input | 1 | I/O device acknowledge |
| io_rdata | input | 32 | I/O device read data |

## Verification
Accesses are run through both mapping modes using offsets chosen to tell them apart. One offset has high bits that contiguous mode must drop and sparse mode must keep. The top page with all low bits set must produce port 0xFFFF in sparse mode, and offset zero checks the base. Each size is paired with both endian settings and with data whose bytes are all distinct, so an exchange, a reversal, a missed zeroing of upper lanes or a swap applied to bytes each shows up as a distinct wrong value. Directed cases cover the edges of the address window, the reserved size code, a delayed device acknowledge, configuration changes made while an access is in flight, and a request held across the acknowledge.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } br_state_e;
endpackage

// File: rtl/iowin_xlate.sv
module iowin_xlate #(
  parameter int unsigned      ADDR_W     = 32,
  parameter int unsigned      PORT_W     = 16,
  parameter int unsigned      LOW_BITS   = 5,
  parameter int unsigned      PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  parameter logic [ADDR_W:0]   WIN_BYTES = 33'h0_0080_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sparse,
  output logic              hit,
  output logic [PORT_W-1:0] port
);
  localparam logic [ADDR_W:0]   WIN_END   = {1'b0, WIN_BASE} + WIN_BYTES;
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(WIN_BYTES - 1'b1);
  localparam logic [ADDR_W-1:0] LOW_MASK  = (ADDR_W'(1) << LOW_BITS) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    ((ADDR_W'(1) << (PORT_W - LOW_BITS)) - ADDR_W'(1)) << PAGE_SHIFT;
  localparam int unsigned       DROP      = PAGE_SHIFT - LOW_BITS;

  logic [ADDR_W-1:0] off;

  always_comb begin
    hit = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);
    off = (addr - WIN_BASE) & OFF_MASK;
    if (sparse)
      port = PORT_W'((off & LOW_MASK) | ((off & PAGE_MASK) >> DROP));
    else
      port = PORT_W'(off);
  end
endmodule

// File: rtl/iowin_swap.sv
module iowin_swap
  import iowin_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              swap_en,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned BYTES = DATA_W / 8;

  always_comb begin
    dout = '0;
    case (acc_size_e'(size))
      SZ_BYTE: dout[7:0] = din[7:0];
      SZ_HALF: dout[15:0] = swap_en ? {din[7:0], din[15:8]} : din[15:0];
      default: begin
        for (int i = 0; i < BYTES; i++)
          dout[8*i +: 8] = swap_en ? din[8*(BYTES-1-i) +: 8] : din[8*i +: 8];
      end
    endcase
  end
endmodule

// File: rtl/isa_io_window_bridge.sv
module isa_io_window_bridge
  import iowin_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       PORT_W     = 16,
  parameter int unsigned       LOW_BITS   = 5,
  parameter int unsigned       PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
  parameter logic [ADDR_W:0]   WIN_BYTES  = 33'h0_0080_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_sparse,
  input  logic              big_endian,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              io_req,
  output logic              io_we,
  output logic [1:0]        io_size,
  output logic [PORT_W-1:0] io_port,
  output logic [DATA_W-1:0] io_wdata,
  input  logic              io_ack,
  input  logic [DATA_W-1:0] io_rdata
);
  br_state_e         state;
  logic              win_hit;
  logic [PORT_W-1:0] port_nxt;
  logic [DATA_W-1:0] wdata_sw;
  logic [DATA_W-1:0] rdata_sw;
  logic              swap_q;
  logic              accept;

  iowin_xlate #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .LOW_BITS(LOW_BITS),
    .PAGE_SHIFT(PAGE_SHIFT), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_xlate (
    .addr(cpu_addr), .sparse(map_sparse), .hit(win_hit), .port(port_nxt)
  );

  iowin_swap #(.DATA_W(DATA_W)) u_wswap (
    .din(cpu_wdata), .size(cpu_size), .swap_en(big_endian), .dout(wdata_sw)
  );

  iowin_swap #(.DATA_W(DATA_W)) u_rswap (
    .din(io_rdata), .size(io_size), .swap_en(swap_q), .dout(rdata_sw)
  );

  assign accept = (state == ST_IDLE) && cpu_req && win_hit &&
                  (acc_size_e'(cpu_size) != SZ_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      io_req    <= 1'b0;
      io_we     <= 1'b0;
      io_size   <= '0;
      io_port   <= '0;
      io_wdata  <= '0;
      swap_q    <= 1'b0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_BUSY;
          io_req   <= 1'b1;
          io_we    <= cpu_we;
          io_size  <= cpu_size;
          io_port  <= port_nxt;
          io_wdata <= wdata_sw;
          swap_q   <= big_endian;
        end
        ST_BUSY: if (io_ack) begin
          state     <= ST_DONE;
          io_req    <= 1'b0;
          cpu_ack   <= 1'b1;
          cpu_rdata <= rdata_sw;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an I/O cycle starts only from a claimed request
  assert_start_claimed_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(io_req) |-> $past(cpu_req && win_hit && (cpu_size != 2'd3)));

  // R3: an unclaimed address never starts a cycle
  assert_unclaimed_R3: assert property (@(posedge clk) disable iff (rst)
    (!io_req && !cpu_ack && cpu_req && !win_hit) |=> !io_req);

  // R5: sparse mapping keeps the low offset bits as port bits
  assert_sparse_low_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(io_req) && $past(map_sparse)) |->
      (io_port[LOW_BITS-1:0] == $past(cpu_addr[LOW_BITS-1:0])));

  // R9: request fields hold until the device acknowledges
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_ack) |=> (io_req && $stable(io_port) && $stable(io_wdata)));

  // R9: device acknowledge completes the access next cycle
  assert_complete_R9: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_ack) |=> (cpu_ack && !io_req));

  // R9: processor acknowledge is a single-cycle pulse
  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  // R11: no new access starts right after an acknowledge
  assert_gap_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !io_req);
endmodule

// File: tb/sim_isa_io_window_bridge.sv
`timescale 1ns/1ps
module sim_isa_io_window_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_sparse = 1'b0, big_endian = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = 32'd0, cpu_wdata = 32'd0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        io_req, io_we;
  logic [1:0]  io_size;
  logic [15:0] io_port;
  logic [31:0] io_wdata;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = 32'd0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  isa_io_window_bridge u0 (
    .clk(clk), .rst(rst), .map_sparse(map_sparse), .big_endian(big_endian),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .io_req(io_req), .io_we(io_we), .io_size(io_size),
    .io_port(io_port), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
  );

  localparam logic [31:0] T_ADDR [8] = '{32'h8000_03F8, 32'h8000_0092,
    32'h8000_1234, 32'h8000_FFFC, 32'h807F_F01F, 32'h8012_3456,
    32'h8000_0000, 32'h8004_5007};
  localparam logic [1:0]  T_SIZE [8] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd2, 2'd1};
  localparam logic        T_WE   [8] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] T_WD   [8] = '{32'hAABB_CC5A, 32'hDEAD_BEEF,
    32'h1234_5678, 32'h0102_0304, 32'h0, 32'h0, 32'h0, 32'hFFFF_1234};
  localparam logic        T_SPR  [8] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic        T_BE   [8] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] T_RD   [8] = '{32'h1122_3344, 32'h0000_A1B2,
    32'hFFFF_9876, 32'hCAFE_F00D, 32'h89AB_CDEF, 32'h0000_00C3,
    32'h55AA_33CC, 32'h7777_6655};

  function automatic logic [15:0] exp_port(input logic [31:0] a, input logic sp);
    logic [31:0] off;
    off = a - 32'h8000_0000;
    return sp ? {off[22:12], off[4:0]} : off[15:0];
  endfunction

  function automatic logic [31:0] exp_lane(input logic [31:0] d,
                                           input logic [1:0] sz, input logic be);
    case (sz)
      2'd0: return {24'd0, d[7:0]};
      2'd1: return be ? {16'd0, d[7:0], d[15:8]} : {16'd0, d[15:0]};
      default: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] a, input logic [1:0] sz, input logic we,
                       input logic [31:0] wd, input logic sp, input logic be);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_size = sz; cpu_we = we;
    cpu_wdata = wd; map_sparse = sp; big_endian = be;
    @(negedge clk);
  endtask

  task automatic full_access(input int i);
    start(T_ADDR[i], T_SIZE[i], T_WE[i], T_WD[i], T_SPR[i], T_BE[i]);
    chk(io_req == 1'b1 && io_size == T_SIZE[i] && io_we == T_WE[i], "R2",
        "io_req/size/we", {28'd0, io_req, io_we, io_size}, {28'd0, 1'b1, T_WE[i], T_SIZE[i]});
    chk(io_port == exp_port(T_ADDR[i], T_SPR[i]), T_SPR[i] ? "R5" : "R4",
        "io_port", {16'd0, io_port}, {16'd0, exp_port(T_ADDR[i], T_SPR[i])});
    chk(io_wdata == exp_lane(T_WD[i], T_SIZE[i], T_BE[i]),
        T_SIZE[i] == 2'd0 ? "R6" : (T_SIZE[i] == 2'd1 ? "R7" : "R8"),
        "io_wdata", io_wdata, exp_lane(T_WD[i], T_SIZE[i], T_BE[i]));
    io_ack = 1'b1; io_rdata = T_RD[i];
    @(negedge clk);
    chk(cpu_ack == 1'b1 && io_req == 1'b0 &&
        cpu_rdata == exp_lane(T_RD[i], T_SIZE[i], T_BE[i]),
        T_SIZE[i] == 2'd0 ? "R6" : (T_SIZE[i] == 2'd1 ? "R7" : "R8"),
        "cpu_rdata", cpu_rdata, exp_lane(T_RD[i], T_SIZE[i], T_BE[i]));
    io_ack = 1'b0; cpu_req = 1'b0;
    @(negedge clk);
    chk(cpu_ack == 1'b0, "R9", "ack pulse width", {31'd0, cpu_ack}, 32'd0);
  endtask

  task automatic unclaimed(input logic [31:0] a, input logic [1:0] sz);
    start(a, sz, 1'b0, 32'd0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk(io_req == 1'b0 && cpu_ack == 1'b0, "R3", "unclaimed request",
          {30'd0, io_req, cpu_ack}, 32'd0);
      @(negedge clk);
    end
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(io_req == 1'b0 && cpu_ack == 1'b0 && cpu_rdata == 32'd0 && io_port == 16'd0,
        "R1", "reset state", {cpu_rdata[15:0], io_port[13:0], io_req, cpu_ack}, 32'd0);

    for (int i = 0; i < 8; i++) full_access(i);

    // R3: window edges and reserved size
    unclaimed(32'h7FFF_FFFE, 2'd1);
    unclaimed(32'h8080_0000, 2'd0);
    unclaimed(32'h8000_0010, 2'd3);

    // R3 / R4: last byte of window is claimed
    start(32'h807F_FFFF, 2'd0, 1'b1, 32'h0000_00A5, 1'b0, 1'b0);
    chk(io_req == 1'b1 && io_port == 16'hFFFF, "R4", "last window byte",
        {15'd0, io_req, io_port}, {15'd0, 1'b1, 16'hFFFF});
    io_ack = 1'b1;
    @(negedge clk);
    io_ack = 1'b0; cpu_req = 1'b0;
    @(negedge clk);

    // R9: delayed acknowledge, fields held steady
    start(32'h8000_0070, 2'd2, 1'b1, 32'hA1B2_C3D4, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(io_req == 1'b1 && cpu_ack == 1'b0 && io_port == 16'h0070 &&
          io_wdata == 32'hD4C3_B2A1, "R9", "hold while waiting",
          io_wdata, 32'hD4C3_B2A1);
    end
    io_ack = 1'b1;
    @(negedge clk);
    chk(cpu_ack == 1'b1 && io_req == 1'b0, "R9", "complete after late ack",
        {30'd0, cpu_ack, io_req}, 32'd2);
    io_ack = 1'b0; cpu_req = 1'b0;
    @(negedge clk);

    // R10: configuration changed after acceptance
    start(32'h8004_5007, 2'd1, 1'b0, 32'd0, 1'b0, 1'b1);
    map_sparse = 1'b1; big_endian = 1'b0;
    chk(io_port == 16'h5007, "R10", "port uses sampled mode",
        {16'd0, io_port}, 32'h0000_5007);
    io_ack = 1'b1; io_rdata = 32'h0000_1A2B;
    @(negedge clk);
    chk(cpu_rdata == 32'h0000_2B1A, "R10", "swap uses sampled endian",
        cpu_rdata, 32'h0000_2B1A);
    io_ack = 1'b0; cpu_req = 1'b0;
    @(negedge clk);

    // R11: request held across the acknowledge is not re-accepted
    start(32'h8000_0100, 2'd0, 1'b0, 32'd0, 1'b0, 1'b0);
    io_ack = 1'b1; io_rdata = 32'h0000_0042;
    @(negedge clk);
    io_ack = 1'b0;
    @(negedge clk);
    chk(io_req == 1'b0, "R11", "no accept in ack cycle", {31'd0, io_req}, 32'd0);
    cpu_req = 1'b0;
    @(negedge clk);
    chk(io_req == 1'b0 && cpu_ack == 1'b0, "R11", "idle after drop",
        {30'd0, io_req, cpu_ack}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule